// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block steers operand bypassing and load interlocks for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Every cycle it compares the source register numbers of the instructions in decode and execute with the destinations held in the three later pipeline registers. From that comparison it produces a select for each ALU operand, a select that bypasses a just-loaded value into the store-data path of the memory stage, and the controls that freeze the front of the pipeline for one cycle.

ALU results are bypassed from the execute/memory and memory/writeback registers, so dependent ALU instructions do not stall. A value loaded from memory exists only at the end of the memory stage. An instruction that needs it in execute immediately after the load therefore costs one bubble. A store that only writes the loaded register to memory costs no bubble, because the value is bypassed into the memory stage. The register file writes in the first half of a cycle and reads in the second half, so a producer three instructions back needs no bypass. The datapath muxes, register file, ALU and memory are outside this block. The only state the block holds is a one-stage copy of the store information from execute.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `fwd_store` is 0. When no destination matches, both ALU selects are 0 and no stall is raised.
- R2: Each ALU operand select uses the encoding 0 = register file, 1 = execute/memory result, 2 = memory/writeback result. A stage is a bypass source only if its write flag is set and its destination equals the operand's source register.
- R3: When the execute/memory and memory/writeback stages both qualify for the same operand, the select is 1, because the younger result wins.
- R4: Destination register 0 is never a bypass source. An operand whose source is register 0 always selects 0.
- R5: A load held in the execute/memory register is not a bypass source, because its data is not ready yet. The operand falls back to memory/writeback or to the register file.
- R6: The select for operand B is 0 unless the instruction in execute reads Rt as an ALU operand or is a store.
- R7: If the instruction in execute is a load with its write flag set and a nonzero destination, a stall is raised in the same cycle when that destination equals decode's Rs and Rs is read. It is also raised when the destination equals decode's Rt and Rt is read as an ALU operand. The stall drives `stall_pc`, `stall_ifid` and `bubble_idex` all to 1.
- R8: No stall is raised in these cases: the matching register is not read; decode's Rt is used only as store data; the load's destination is register 0; or the instruction in execute is not a load.
- R9: `fwd_store` is 1 in cycle n exactly when the instruction in execute during cycle n-1 was a store, and its Rt equals the current memory/writeback destination, which has its write flag set and is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_W | Rs of the instruction in decode |
| id_rt | input | REG_W | Rt of the instruction in decode |
| id_rs_used | input | 1 | Decode instruction reads Rs |
| id_rt_alu | input | 1 | Decode instruction reads Rt as an ALU operand |
| ex_rs | input | REG_W | Rs of the instruction in execute |
| ex_rt | input | REG_W | Rt of the instruction in execute |
| ex_rt_alu | input | 1 | Execute instruction reads Rt as an ALU operand |
| ex_is_store | input | 1 | Execute instruction is a store |
| idex_rd | input | REG_W | Destination in the decode/execute register |
| idex_wr | input | 1 | Write flag in the decode/execute register |
| idex_load | input | 1 | Load flag in the decode/execute register |
| exmem_rd | input | REG_W | Destination in the execute/memory register |
| exmem_wr | input | 1 | Write flag in the execute/memory register |
| exmem_load | input | 1 | Load flag in the execute/memory register |
| memwb_rd | input | REG_W | Destination in the memory/writeback register |
| memwb_wr | input | 1 | Write flag in the memory/writeback register |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| fwd_store | output | 1 | Bypass the writeback value into the memory-stage store data |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Clear the controls entering decode/execute |

## Verification
The bench drives these patterns, each separating one decision from the others:
- A back-to-back ALU dependency against the same register produced two and three instructions back, which tells the 1, 2 and 0 selects apart.
- Both later stages matching at once, to show that the younger result wins.
- Register 0 as source and as destination.
- A load sitting in execute/memory.
- A load followed by a consumer of Rs, of ALU Rt, of store-data Rt only, and by an instruction that does not read the register, which separates a real interlock from a false one.
- Store sequences with a matching and a mismatching writeback destination, which show that the memory-stage bypass follows the store by exactly one cycle.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } src_sel_e;

endpackage

// File: rtl/opnd_bypass.sv
module opnd_bypass
    import fwd_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wr,
    input  logic             exmem_load,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wr,
    output logic [1:0]       sel
);

    logic hit_exmem;
    logic hit_memwb;

    always_comb begin
        // a load in EX/MEM has no data yet, so it never feeds the bypass
        hit_exmem = src_used && exmem_wr && !exmem_load
                    && (exmem_rd != '0) && (exmem_rd == src);
        hit_memwb = src_used && memwb_wr
                    && (memwb_rd != '0) && (memwb_rd == src);
        if (hit_exmem)
            sel = SRC_EXMEM;
        else if (hit_memwb)
            sel = SRC_MEMWB;
        else
            sel = SRC_RF;
    end

endmodule

// File: rtl/load_interlock.sv
module load_interlock #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_rs_used,
    input  logic             id_rt_alu,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_wr,
    input  logic             idex_load,
    output logic             stall
);

    logic load_live;

    always_comb begin
        load_live = idex_load && idex_wr && (idex_rd != '0);
        stall = load_live && ((id_rs_used && (id_rs == idex_rd))
                           || (id_rt_alu && (id_rt == idex_rd)));
    end

endmodule

// File: rtl/store_bypass.sv
module store_bypass #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_store,
    input  logic [REG_W-1:0] ex_rt,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wr,
    output logic             fwd_store
);

    typedef struct packed {
        logic             st;
        logic [REG_W-1:0] rt;
    } mem_slot_t;

    mem_slot_t slot_d, slot_q;

    always_comb begin
        slot_d.st = ex_is_store;
        slot_d.rt = ex_rt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_d;
    end

    assign fwd_store = slot_q.st && memwb_wr && (memwb_rd != '0)
                       && (memwb_rd == slot_q.rt);

    a_r9_store_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_store |-> ($past(ex_is_store) && ($past(ex_rt) == memwb_rd)));

    a_r1_store_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> !fwd_store);

endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
    import fwd_hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_rs_used,
    input  logic             id_rt_alu,
    input  logic [REG_W-1:0] ex_rs,
    input  logic [REG_W-1:0] ex_rt,
    input  logic             ex_rt_alu,
    input  logic             ex_is_store,
    input  logic [REG_W-1:0] idex_rd,
    input  logic             idex_wr,
    input  logic             idex_load,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wr,
    input  logic             exmem_load,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wr,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             fwd_store,
    output logic             stall_pc,
    output logic             stall_ifid,
    output logic             bubble_idex
);

    localparam int NUM_OPND = 2;

    logic [REG_W-1:0] opnd_src  [NUM_OPND];
    logic             opnd_used [NUM_OPND];
    logic [1:0]       opnd_sel  [NUM_OPND];
    logic             stall;

    always_comb begin
        opnd_src[0]  = ex_rs;
        opnd_used[0] = 1'b1;
        opnd_src[1]  = ex_rt;
        opnd_used[1] = ex_rt_alu || ex_is_store;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        opnd_bypass #(.REG_W(REG_W)) u_byp (
            .src        (opnd_src[g]),
            .src_used   (opnd_used[g]),
            .exmem_rd   (exmem_rd),
            .exmem_wr   (exmem_wr),
            .exmem_load (exmem_load),
            .memwb_rd   (memwb_rd),
            .memwb_wr   (memwb_wr),
            .sel        (opnd_sel[g])
        );
    end

    assign fwd_a = opnd_sel[0];
    assign fwd_b = opnd_sel[1];

    load_interlock #(.REG_W(REG_W)) u_lock (
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .id_rs_used (id_rs_used),
        .id_rt_alu  (id_rt_alu),
        .idex_rd    (idex_rd),
        .idex_wr    (idex_wr),
        .idex_load  (idex_load),
        .stall      (stall)
    );

    assign stall_pc    = stall;
    assign stall_ifid  = stall;
    assign bubble_idex = stall;

    store_bypass #(.REG_W(REG_W)) u_stbyp (
        .clk         (clk),
        .rst_n       (rst_n),
        .ex_is_store (ex_is_store),
        .ex_rt       (ex_rt),
        .memwb_rd    (memwb_rd),
        .memwb_wr    (memwb_wr),
        .fwd_store   (fwd_store)
    );

    a_r3_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_wr && !exmem_load && exmem_rd != '0 && exmem_rd == ex_rs)
            |-> (fwd_a == SRC_EXMEM));

    a_r4_zero_src_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == '0) |-> (fwd_a == SRC_RF));

    a_r5_load_not_source: assert property (@(posedge clk) disable iff (!rst_n)
        exmem_load |-> (fwd_a != SRC_EXMEM && fwd_b != SRC_EXMEM));

    a_r6_b_unused_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_rt_alu && !ex_is_store) |-> (fwd_b == SRC_RF));

    a_r8_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall_pc |-> (idex_load && idex_wr && idex_rd != '0));

    a_r2_memwb_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == SRC_MEMWB) |-> (memwb_wr && memwb_rd == ex_rs));

endmodule

// File: tb/fwd_hazard_ctrl_test.sv
module fwd_hazard_ctrl_test;

    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] id_rs, id_rt, ex_rs, ex_rt, idex_rd, exmem_rd, memwb_rd;
    logic id_rs_used, id_rt_alu, ex_rt_alu, ex_is_store;
    logic idex_wr, idex_load, exmem_wr, exmem_load, memwb_wr;
    logic [1:0] fwd_a, fwd_b;
    logic fwd_store, stall_pc, stall_ifid, bubble_idex;

    fwd_hazard_ctrl #(.REG_W(W)) uut (.*);

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       st;
        logic       stall;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    logic prev_store = 1'b0;
    logic [W-1:0] prev_rt = '0;

    function automatic logic [1:0] model_sel(logic [W-1:0] s, logic used);
        if (used && exmem_wr && !exmem_load && exmem_rd != 0 && exmem_rd == s) return 2'd1;
        if (used && memwb_wr && memwb_rd != 0 && memwb_rd == s) return 2'd2;
        return 2'd0;
    endfunction

    task automatic idle_inputs();
        id_rs = 0; id_rt = 0; id_rs_used = 0; id_rt_alu = 0;
        ex_rs = 0; ex_rt = 0; ex_rt_alu = 0; ex_is_store = 0;
        idex_rd = 0; idex_wr = 0; idex_load = 0;
        exmem_rd = 0; exmem_wr = 0; exmem_load = 0;
        memwb_rd = 0; memwb_wr = 0;
    endtask

    // called after inputs for this cycle are set; computes expected values
    task automatic push_exp(string tag);
        exp_t e;
        e.a = model_sel(ex_rs, 1'b1);
        e.b = model_sel(ex_rt, ex_rt_alu || ex_is_store);
        e.st = prev_store && memwb_wr && memwb_rd != 0 && memwb_rd == prev_rt;
        e.stall = idex_load && idex_wr && idex_rd != 0 &&
                  ((id_rs_used && id_rs == idex_rd) || (id_rt_alu && id_rt == idex_rd));
        e.tag = tag;
        exp_q.push_back(e);
        prev_store = ex_is_store;
        prev_rt = ex_rt;
    endtask

    task automatic step(string tag);
        push_exp(tag);
        @(posedge clk);
        #1;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (fwd_a !== e.a || fwd_b !== e.b || fwd_store !== e.st ||
                    stall_pc !== e.stall || stall_ifid !== e.stall || bubble_idex !== e.stall) begin
                    errors++;
                    $display("FAIL %s: got a=%0d b=%0d st=%0b stall=%0b%0b%0b exp a=%0d b=%0d st=%0b stall=%0b",
                             e.tag, fwd_a, fwd_b, fwd_store, stall_pc, stall_ifid, bubble_idex,
                             e.a, e.b, e.st, e.stall);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : driver
        idle_inputs();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, store bypass held low during reset
        memwb_rd = 3; memwb_wr = 1; ex_is_store = 1; ex_rt = 3;
        @(negedge clk);
        checks++;
        if (fwd_store !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: fwd_store=%0b exp 0", fwd_store);
        end
        idle_inputs();
        @(posedge clk); #1;
        rst_n = 1'b1;
        prev_store = 0; prev_rt = 0;
        step("R1 idle after reset");

        // R2: EX/MEM bypass on A and MEM/WB on B
        ex_rs = 4; ex_rt = 6; ex_rt_alu = 1;
        exmem_rd = 4; exmem_wr = 1; memwb_rd = 6; memwb_wr = 1;
        step("R2 A from EX/MEM B from MEM/WB");
        idle_inputs();
        // R2: write flag low blocks bypass
        ex_rs = 4; exmem_rd = 4; exmem_wr = 0;
        step("R2 write flag low");
        idle_inputs();
        // R3: both stages match
        ex_rs = 7; ex_rt = 7; ex_rt_alu = 1;
        exmem_rd = 7; exmem_wr = 1; memwb_rd = 7; memwb_wr = 1;
        step("R3 younger wins");
        idle_inputs();
        // R4: register 0
        ex_rs = 0; ex_rt = 0; ex_rt_alu = 1;
        exmem_rd = 0; exmem_wr = 1; memwb_rd = 0; memwb_wr = 1;
        step("R4 register zero");
        idle_inputs();
        // R5: load in EX/MEM falls to MEM/WB
        ex_rs = 9; exmem_rd = 9; exmem_wr = 1; exmem_load = 1;
        memwb_rd = 9; memwb_wr = 1;
        step("R5 load in EX/MEM");
        idle_inputs();
        // R6: B unused
        ex_rt = 5; ex_rt_alu = 0; exmem_rd = 5; exmem_wr = 1;
        step("R6 Rt not read");
        idle_inputs();
        // R7: load-use on Rs
        idex_rd = 8; idex_wr = 1; idex_load = 1; id_rs = 8; id_rs_used = 1;
        step("R7 load-use Rs");
        idle_inputs();
        // R7: load-use on ALU Rt
        idex_rd = 10; idex_wr = 1; idex_load = 1; id_rt = 10; id_rt_alu = 1;
        step("R7 load-use Rt");
        idle_inputs();
        // R8: Rt used only as store data
        idex_rd = 10; idex_wr = 1; idex_load = 1; id_rt = 10; id_rt_alu = 0;
        step("R8 store data no stall");
        idle_inputs();
        // R8: ALU producer, not load
        idex_rd = 11; idex_wr = 1; id_rs = 11; id_rs_used = 1;
        step("R8 non-load producer");
        idle_inputs();
        // R8: load to register 0, and Rs not read
        idex_rd = 0; idex_wr = 1; idex_load = 1; id_rs = 0; id_rs_used = 1;
        step("R8 load to r0");
        idle_inputs();
        idex_rd = 12; idex_wr = 1; idex_load = 1; id_rs = 12; id_rs_used = 0;
        step("R8 Rs unread");
        idle_inputs();
        // R9: store in execute, then loaded value reaches writeback
        ex_is_store = 1; ex_rt = 13; ex_rs = 2;
        step("R9 store in execute");
        idle_inputs();
        memwb_rd = 13; memwb_wr = 1;
        step("R9 store bypass one cycle later");
        idle_inputs();
        memwb_rd = 13; memwb_wr = 1;
        step("R9 no bypass without prior store");
        ex_is_store = 1; ex_rt = 14;
        step("R9 store mismatch setup");
        idle_inputs();
        memwb_rd = 15; memwb_wr = 1;
        step("R9 mismatch");
        idle_inputs();
        // R2: three-back producer needs nothing
        ex_rs = 3; ex_rt = 3; ex_rt_alu = 1;
        step("R2 register file only");
        idle_inputs();
        step("R1 idle tail");
        @(posedge clk); @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule